// File: doc/BRIEF.md
# Register scoreboard issue interlock

This block decides, once per cycle, whether the single decoded instruction at the head of an in-order pipeline may enter execution. It keeps one readiness flag per architectural register. A flag goes low when an instruction that writes that register is sent to execution. It goes high again when the execution unit reports that it has written the result. Because the execution units can take several cycles, later instructions that read a pending register are held back by this block.

Each cycle the decode stage presents a destination index, two source indices and a mask that says which sources are actually read. The execution units present a completion index with a write strobe. A completion in the current cycle already counts as ready, so a dependent instruction can go in the cycle its operand returns. An instruction is also held while its destination still has a write pending, which keeps writes to the same register in order. A held instruction stays at the head and blocks everything behind it until the check passes. The decision is purely combinational from the current inputs and the stored flags.

Top module: `reg_scoreboard`

## Requirements
- R1: After reset every bit of `rdy_vec` is 1.
- R2: An instruction issues only if each source it reads is ready. `src_mask` bit 0 enables source A and bit 1 enables source B. A source whose mask bit is 0 has no effect on the decision.
- R3: When an instruction issues with a destination other than 0, that destination's bit in `rdy_vec` is 0 from the next cycle on.
- R4: `stall` is 1 exactly when `dec_vld` is 1 and `issue_ok` is 0. `issue_ok` and `stall` are never both 1, and both are 0 when `dec_vld` is 0.
- R5: When `cmp_we` is 1, the bit for `cmp_idx` in `rdy_vec` is 1 in the next cycle, unless R8 applies.
- R6: An instruction whose destination is not ready stalls, even when all of its sources are ready.
- R7: A register named by `cmp_idx` while `cmp_we` is 1 counts as ready in the same cycle, both as a source and as a destination.
- R8: If an issue and a completion name the same register in one cycle, the register's bit is 0 in the next cycle.
- R9: Register 0 is always ready. It is never cleared by an issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld | input | 1 | A decoded instruction is presented |
| dec_dst | input | IDX_W | Destination register index |
| dec_srca | input | IDX_W | Source A register index |
| dec_srcb | input | IDX_W | Source B register index |
| src_mask | input | 2 | Bit 0 enables source A, bit 1 enables source B |
| cmp_we | input | 1 | An execution unit writes back this cycle |
| cmp_idx | input | IDX_W | Register written back |
| issue_ok | output | 1 | The presented instruction issues this cycle |
| stall | output | 1 | The presented instruction is held |
| rdy_vec | output | NUM_REGS | Ready flag of every register |

## Verification
The two functions that can fall in the same cycle are issue and write-back. They interact in two ways: write-back feeding the issue check through bypass, and issue and write-back acting on the same register. The random phase confines all indices to eight registers and keeps completion traffic dense, so both overlaps come up often. Directed cases force each overlap on purpose. Each result is judged in two places. The issue decision is checked in the same cycle against a bench model of the flags. The next cycle's `rdy_vec` is then compared with the model, which gives clear priority over set.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // One-hot decode of a register index, gated by an enable
  function automatic logic [63:0] idx_hot(input int unsigned idx, input logic en);
    logic [63:0] v;
    v = '0;
    if (en) v[idx] = 1'b1;
    return v;
  endfunction

  // A register is usable if stored ready, bypassed this cycle, or register 0
  function automatic logic usable(input logic stored, input logic byp, input logic is_zero);
    return stored | byp | is_zero;
  endfunction

endpackage

// File: rtl/sb_ready_table.sv
module sb_ready_table #(
  parameter int NUM_REGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] set_vec,
  input  logic [NUM_REGS-1:0] clr_vec,
  output logic [NUM_REGS-1:0] rdy
);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == 0) begin : g_zero
        assign rdy[g] = 1'b1;
      end else begin : g_flop
        logic bit_q;
        always_ff @(posedge clk) begin
          if (!rst_n)          bit_q <= 1'b1;
          else if (clr_vec[g]) bit_q <= 1'b0;  // issue clear wins over set
          else if (set_vec[g]) bit_q <= 1'b1;
        end
        assign rdy[g] = bit_q;
      end
    end
  endgenerate

  // R8: a register cleared and set together ends up not ready
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[1] && set_vec[1]) |=> !rdy[1]);

endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0] rdy,
  input  logic [NUM_REGS-1:0] byp,
  input  logic                dec_vld,
  input  logic [IDX_W-1:0]    dec_dst,
  input  logic [IDX_W-1:0]    dec_srca,
  input  logic [IDX_W-1:0]    dec_srcb,
  input  logic [1:0]          src_mask,
  output logic                issue_ok,
  output logic                stall
);

  logic srca_ok, srcb_ok, dst_ok;

  always_comb begin
    srca_ok = !src_mask[0] ||
              usable(rdy[dec_srca], byp[dec_srca], dec_srca == '0);
    srcb_ok = !src_mask[1] ||
              usable(rdy[dec_srcb], byp[dec_srcb], dec_srcb == '0);
    dst_ok  = usable(rdy[dec_dst], byp[dec_dst], dec_dst == '0);
    issue_ok = dec_vld && srca_ok && srcb_ok && dst_ok;
    stall    = dec_vld && !issue_ok;
  end

endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dec_vld,
  input  logic [IDX_W-1:0]    dec_dst,
  input  logic [IDX_W-1:0]    dec_srca,
  input  logic [IDX_W-1:0]    dec_srcb,
  input  logic [1:0]          src_mask,
  input  logic                cmp_we,
  input  logic [IDX_W-1:0]    cmp_idx,
  output logic                issue_ok,
  output logic                stall,
  output logic [NUM_REGS-1:0] rdy_vec
);

  logic [63:0]          set_full, clr_full;
  logic [NUM_REGS-1:0]  set_vec, clr_vec;
  logic                 issue_evt;

  assign set_full = idx_hot(int'(cmp_idx), cmp_we);
  assign set_vec  = set_full[NUM_REGS-1:0];
  assign clr_full = idx_hot(int'(dec_dst), issue_evt);
  assign clr_vec  = clr_full[NUM_REGS-1:0];

  sb_issue_check #(.NUM_REGS(NUM_REGS)) u_check (
    .rdy      (rdy_vec),
    .byp      (set_vec),
    .dec_vld  (dec_vld),
    .dec_dst  (dec_dst),
    .dec_srca (dec_srca),
    .dec_srcb (dec_srcb),
    .src_mask (src_mask),
    .issue_ok (issue_evt),
    .stall    (stall)
  );

  sb_ready_table #(.NUM_REGS(NUM_REGS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .rdy     (rdy_vec)
  );

  assign issue_ok = issue_evt;

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_ok && stall) && (dec_vld || (!issue_ok && !stall)));

  a_r9_zero_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_vec[0]);

  a_r3_dst_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && dec_dst != '0) |=> !rdy_vec[$past(dec_dst)]);

  a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we && !(issue_ok && dec_dst == cmp_idx)) |=> rdy_vec[$past(cmp_idx)]);

  a_r6_waw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_dst != '0 && !rdy_vec[dec_dst] &&
     !(cmp_we && cmp_idx == dec_dst)) |-> stall);

  a_r2_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && src_mask[0] && dec_srca != '0 && !rdy_vec[dec_srca] &&
     !(cmp_we && cmp_idx == dec_srca)) |-> !issue_ok);

endmodule

// File: tb/reg_scoreboard_bench.sv
module reg_scoreboard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS = 32;
  localparam int IDX_W = $clog2(NUM_REGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_vld = 1'b0;
  logic [IDX_W-1:0] dec_dst = '0, dec_srca = '0, dec_srcb = '0, cmp_idx = '0;
  logic [1:0] src_mask = '0;
  logic cmp_we = 1'b0;
  logic issue_ok, stall;
  logic [NUM_REGS-1:0] rdy_vec;

  int checks = 0;
  int errors = 0;
  logic [NUM_REGS-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_scoreboard #(.NUM_REGS(NUM_REGS)) u_reg_scoreboard (
    .clk(clk), .rst_n(rst_n), .dec_vld(dec_vld), .dec_dst(dec_dst),
    .dec_srca(dec_srca), .dec_srcb(dec_srcb), .src_mask(src_mask),
    .cmp_we(cmp_we), .cmp_idx(cmp_idx), .issue_ok(issue_ok),
    .stall(stall), .rdy_vec(rdy_vec)
  );

  function automatic bit ready_now(input logic [NUM_REGS-1:0] m, input int r,
                                   input bit we, input int ci);
    if (r == 0) return 1;
    if (we && ci == r) return 1;
    return m[r];
  endfunction

  function automatic bit exp_issue(input logic [NUM_REGS-1:0] m, input bit v,
                                   input int d, input int a, input int b,
                                   input logic [1:0] mk, input bit we, input int ci);
    if (!v) return 0;
    if (mk[0] && !ready_now(m, a, we, ci)) return 0;
    if (mk[1] && !ready_now(m, b, we, ci)) return 0;
    return ready_now(m, d, we, ci);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check decision, update model at posedge
  task automatic step(input bit v, input int d, input int a, input int b,
                      input logic [1:0] mk, input bit we, input int ci, input string tag);
    bit ei;
    @(negedge clk);
    check({"R3 R5 R8 rdy_vec ", tag}, 64'(rdy_vec), 64'(model));
    dec_vld = v; dec_dst = IDX_W'(d); dec_srca = IDX_W'(a); dec_srcb = IDX_W'(b);
    src_mask = mk; cmp_we = we; cmp_idx = IDX_W'(ci);
    #1;
    ei = exp_issue(model, v, d, a, b, mk, we, ci);
    check({"R2 R6 R7 issue_ok ", tag}, 64'(issue_ok), 64'(ei));
    check({"R4 stall ", tag}, 64'(stall), 64'(v && !ei));
    @(posedge clk);
    if (we) model[ci] = 1'b1;
    if (ei && d != 0) model[d] = 1'b0;   // R8: clear after set
    model[0] = 1'b1;                      // R9
  endtask

  initial begin
    void'($urandom(32'd2024));
    model = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1 reset rdy_vec", 64'(rdy_vec), 64'({NUM_REGS{1'b1}}));
    check("R4 idle issue_ok", 64'(issue_ok), 64'd0);

    // R3 issue r3, then r3 reader stalls (R2), WAW on r3 stalls (R6)
    step(1, 3, 2, 2, 2'b11, 0, 0, "R3 issue");
    step(1, 4, 3, 6, 2'b11, 0, 0, "R2 src stale");
    step(1, 3, 1, 1, 2'b00, 0, 0, "R6 waw");
    // R2 unused stale source ignored
    step(1, 5, 3, 6, 2'b10, 0, 0, "R2 masked src");
    // R7 bypass of r3 as source
    step(1, 4, 3, 6, 2'b11, 1, 3, "R7 src bypass");
    // R7 bypass of r5 as destination
    step(1, 5, 0, 0, 2'b00, 1, 5, "R7 dst bypass");
    // R8 issue to r7 while r7 completes (r7 ready)
    step(1, 7, 1, 1, 2'b01, 1, 7, "R8 same reg");
    step(0, 0, 0, 0, 2'b00, 0, 0, "R8 after");
    // R9 writes to r0 never stale
    step(1, 0, 0, 0, 2'b11, 0, 0, "R9 dst0");
    step(1, 0, 0, 0, 2'b11, 0, 0, "R9 again");
    // R5 completions restore r4, r5, r7
    step(0, 0, 0, 0, 2'b00, 1, 4, "R5 set r4");
    step(0, 0, 0, 0, 2'b00, 1, 5, "R5 set r5");
    step(0, 0, 0, 0, 2'b00, 1, 7, "R5 set r7");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), 2'($urandom), ($urandom % 2) == 1,
           $urandom_range(0, 7), "random");
    end
    @(negedge clk);
    check("R5 final rdy_vec", 64'(rdy_vec), 64'(model));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule